// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two predictors run side by side. The first is a table of 2-bit saturating counters indexed only by low bits of the branch address. The second is a correlating table. It uses the same kind of counters, but each address owns one counter for every pattern of the most recent global branch outcomes. A third table of 2-bit counters, indexed per address, learns which of the two predictors to trust for each branch.

A fetch stage presents a lookup address and reads the prediction back in the same cycle. When a branch resolves, the back end presents its address and its real direction on the update port. The block then trains the counters that made the guess, trains the chooser when the two predictors disagreed, and shifts the outcome into the history register.

Top module: `branch_tourney_pred`

## Requirements
- R1: After reset every direction counter holds weakly-not-taken (value 1) and every chooser counter holds value 1, which favours the per-address predictor. As a result, every lookup address predicts not taken.
- R2: The per-address and chooser tables are indexed by the address bits starting at bit PC_LSB. No tag is kept, so two addresses that differ only outside those bits share one entry and get the same prediction.
- R3: A counter saturates at 0 and 3. A taken outcome moves it up by one and a not-taken outcome moves it down by one. Values 2 and 3 predict taken.
- R4: Each valid update shifts its outcome into the global history register. The newest outcome goes into bit 0 and the oldest falls out of the top bit.
- R5: The correlating counter is chosen by the concatenation {address index bits, global history}. Only that one counter is trained by an update.
- R6: The chooser counter at the updated address changes only when the two predictors disagreed for that update. It moves up when the correlating predictor was right and down when the per-address predictor was right. Chooser values 2 and 3 select the correlating prediction.
- R7: The prediction depends combinationally on the lookup address. An update is visible from the cycle after its clock edge, including when the update and the lookup hit the same entry in the same cycle.
- R8: While upd_valid is low, the update address and direction have no effect on any table or on the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_pc | input | PC_W | Address of the branch being fetched |
| pred_taken | output | 1 | Predicted direction for lkp_pc, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real direction of the resolved branch |

## Verification
A strictly alternating branch separates the two predictors. The per-address counter mispredicts it on every outcome, while the correlating counters learn it perfectly. This pattern is the one that proves the chooser migrates to the correlating side. A taken-taken-taken-not-taken loop and a branch whose direction copies a neighbouring branch's last outcome exercise history indexing and cross-branch correlation. A long pseudo-random sweep over eight addresses, aliasing addresses, same-cycle update and lookup, and updates held off with upd_valid low cover saturation at both ends, index folding, update timing and the ignored inputs.

// File: rtl/bp_tourney_pkg.sv
// Shared counter type and saturating-step helpers for the tournament predictor.
// Assumes 2-bit counters whose top bit is the predicted direction.
package bp_tourney_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_SNT = 2'd0;
    localparam ctr2_t CTR_WNT = 2'd1;
    localparam ctr2_t CTR_WT  = 2'd2;
    localparam ctr2_t CTR_ST  = 2'd3;

    // One saturating step of a 2-bit counter, up when inc is set.
    function automatic ctr2_t ctr_step(ctr2_t c, logic inc);
        if (inc)
            return (c == CTR_ST) ? CTR_ST : c + 2'd1;
        else
            return (c == CTR_SNT) ? CTR_SNT : c - 2'd1;
    endfunction

    // Direction implied by a counter value.
    function automatic logic ctr_dir(ctr2_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/bp_ctr_table.sv
// Table of 2-bit saturating counters with one combinational lookup read,
// one combinational read at the update index and one saturating write.
// Assumes a single update per cycle; a write lands on the clock edge.
module bp_ctr_table
    import bp_tourney_pkg::*;
#(
    parameter int    IDX_W = 6,
    parameter ctr2_t INIT  = CTR_WNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_ctr,
    input  logic [IDX_W-1:0] up_idx,
    output ctr2_t            up_ctr,
    input  logic             up_en,
    input  logic             up_inc
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t mem [DEPTH];

    // Reset all counters to INIT, otherwise step the addressed counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= INIT;
        end else if (up_en) begin
            mem[up_idx] <= ctr_step(mem[up_idx], up_inc);
        end
    end

    // Present the lookup and update-side counter values.
    always_comb begin
        rd_ctr = mem[rd_idx];
        up_ctr = mem[up_idx];
    end

endmodule

// File: rtl/bp_hist_reg.sv
// Global outcome history: shifts a resolved direction into bit 0 on each
// enabled cycle. Assumes HIST_W >= 1; a one-bit history just holds the last outcome.
module bp_hist_reg #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_in,
    output logic [HIST_W-1:0] hist
);
    generate
        if (HIST_W == 1) begin : g_single
            // Hold only the latest outcome.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist <= '0;
                else if (shift_en) hist <= shift_in;
            end
        end else begin : g_shift
            // Shift left, newest outcome into bit 0.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist <= '0;
                else if (shift_en) hist <= {hist[HIST_W-2:0], shift_in};
            end
        end
    endgenerate

endmodule

// File: rtl/branch_tourney_pred.sv
// Tournament branch direction predictor: a per-address counter table and a
// history-correlated counter table, with a per-address chooser table.
// Assumes at most one update per cycle and that the caller orders updates
// before dependent lookups; lookups are combinational from the tables.
module branch_tourney_pred
    import bp_tourney_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int LOC_IDX_W = 6,
    parameter int GLB_PC_W  = 6,
    parameter int HIST_W    = 2,
    parameter int SEL_IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lkp_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int GLB_IDX_W = GLB_PC_W + HIST_W;

    logic [HIST_W-1:0]    ghr_q;
    logic [LOC_IDX_W-1:0] loc_lkp_idx, loc_upd_idx;
    logic [GLB_IDX_W-1:0] glb_lkp_idx, glb_upd_idx;
    logic [SEL_IDX_W-1:0] sel_lkp_idx, sel_upd_idx;
    ctr2_t loc_rd_ctr, loc_up_ctr;
    ctr2_t glb_rd_ctr, glb_up_ctr;
    ctr2_t sel_rd_ctr, sel_up_ctr;
    logic  sel_train, sel_inc;

    // Slice table indices from the addresses and the history.
    always_comb begin
        loc_lkp_idx = lkp_pc[PC_LSB +: LOC_IDX_W];
        loc_upd_idx = upd_pc[PC_LSB +: LOC_IDX_W];
        glb_lkp_idx = {lkp_pc[PC_LSB +: GLB_PC_W], ghr_q};
        glb_upd_idx = {upd_pc[PC_LSB +: GLB_PC_W], ghr_q};
        sel_lkp_idx = lkp_pc[PC_LSB +: SEL_IDX_W];
        sel_upd_idx = upd_pc[PC_LSB +: SEL_IDX_W];
    end

    bp_ctr_table #(.IDX_W(LOC_IDX_W), .INIT(CTR_WNT)) u_loc_tbl (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(loc_lkp_idx), .rd_ctr(loc_rd_ctr),
        .up_idx(loc_upd_idx), .up_ctr(loc_up_ctr),
        .up_en(upd_valid), .up_inc(upd_taken)
    );

    bp_ctr_table #(.IDX_W(GLB_IDX_W), .INIT(CTR_WNT)) u_glb_tbl (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(glb_lkp_idx), .rd_ctr(glb_rd_ctr),
        .up_idx(glb_upd_idx), .up_ctr(glb_up_ctr),
        .up_en(upd_valid), .up_inc(upd_taken)
    );

    // Train the chooser only on disagreement, toward the correct predictor.
    always_comb begin
        sel_train = upd_valid && (ctr_dir(loc_up_ctr) != ctr_dir(glb_up_ctr));
        sel_inc   = (ctr_dir(glb_up_ctr) == upd_taken);
    end

    bp_ctr_table #(.IDX_W(SEL_IDX_W), .INIT(CTR_WNT)) u_sel_tbl (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(sel_lkp_idx), .rd_ctr(sel_rd_ctr),
        .up_idx(sel_upd_idx), .up_ctr(sel_up_ctr),
        .up_en(sel_train), .up_inc(sel_inc)
    );

    bp_hist_reg #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .shift_en(upd_valid), .shift_in(upd_taken),
        .hist(ghr_q)
    );

    // Final choice between the two direction guesses.
    always_comb begin
        pred_taken = ctr_dir(sel_rd_ctr) ? ctr_dir(glb_rd_ctr) : ctr_dir(loc_rd_ctr);
    end

endmodule

// File: rtl/bp_tourney_checker.sv
// Protocol and state checks for the tournament predictor, bound to the top.
// Assumes reset is held for at least one clock edge at start-up.
module bp_tourney_checker
    import bp_tourney_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int HIST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   lkp_pc,
    input logic              pred_taken,
    input logic              upd_valid,
    input logic [PC_W-1:0]   upd_pc,
    input logic              upd_taken,
    input logic [HIST_W-1:0] hist,
    input ctr2_t             loc_rd,
    input ctr2_t             loc_up,
    input ctr2_t             glb_up,
    input ctr2_t             sel_up
);
    // Widened counter values so that steps can be compared without wrap.
    logic [2:0] loc_rd_w;
    always_comb loc_rd_w = {1'b0, loc_rd};

    p_reset_nt_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !pred_taken);

    p_ctr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_pc == $past(lkp_pc)) |->
            ((loc_rd_w == {1'b0, $past(loc_rd)}) ||
             (loc_rd_w == {1'b0, $past(loc_rd)} + 3'd1) ||
             (loc_rd_w + 3'd1 == {1'b0, $past(loc_rd)})));

    p_hist_newest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (hist[0] == $past(upd_taken)));

    generate
        if (HIST_W > 1) begin : g_shift_chk
            p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
                upd_valid |=> (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));
        end
    endgenerate

    p_sel_agree_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (loc_up[1] == glb_up[1])) |=>
            ((upd_pc != $past(upd_pc)) || $stable(sel_up)));

    p_idle_hist_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist));

    p_idle_pred_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ((lkp_pc != $past(lkp_pc)) || $stable(pred_taken)));

endmodule

bind branch_tourney_pred bp_tourney_checker #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .hist(ghr_q), .loc_rd(loc_rd_ctr), .loc_up(loc_up_ctr),
    .glb_up(glb_up_ctr), .sel_up(sel_up_ctr)
);

// File: tb/branch_tourney_pred_test.sv
`timescale 1ns/1ps
// Self-checking bench: an arithmetic reference of the three tables and the
// history, driven through several outcome patterns on the default configuration.
module branch_tourney_pred_test;
    localparam int PC_W = 32;
    localparam int LSB  = 2;
    localparam int LW   = 6;
    localparam int HW   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lkp_pc = '0;
    logic            pred_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [1:0] m_loc [64];
    logic [1:0] m_glb [256];
    logic [1:0] m_sel [64];
    logic [1:0] m_hist;

    branch_tourney_pred uut (
        .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    always #4 clk = ~clk;

    function automatic int li(logic [PC_W-1:0] pc);
        return int'((pc >> LSB) & 32'd63);
    endfunction

    function automatic logic [1:0] sat(logic [1:0] c, logic up);
        if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    function automatic logic m_pred(logic [PC_W-1:0] pc);
        int a = li(pc);
        int g = a * 4 + int'(m_hist);
        return m_sel[a][1] ? m_glb[g][1] : m_loc[a][1];
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 64; i++) begin m_loc[i] = 2'd1; m_sel[i] = 2'd1; end
        for (int i = 0; i < 256; i++) m_glb[i] = 2'd1;
        m_hist = 2'd0;
    endtask

    task automatic m_update(logic [PC_W-1:0] pc, logic t);
        int a = li(pc);
        int g = a * 4 + int'(m_hist);
        if (m_loc[a][1] != m_glb[g][1])
            m_sel[a] = sat(m_sel[a], m_glb[g][1] == t);
        m_loc[a] = sat(m_loc[a], t);
        m_glb[g] = sat(m_glb[g], t);
        m_hist = {m_hist[0], t};
    endtask

    task automatic chk(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
    endtask

    // Lookup one address and compare with the reference.
    task automatic look(logic [PC_W-1:0] pc, string req);
        @(negedge clk);
        lkp_pc = pc;
        #1;
        chk(req, pred_taken, m_pred(pc));
    endtask

    // One resolved branch on the update port for one edge.
    task automatic upd(logic [PC_W-1:0] pc, logic t);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc = pc;
        upd_taken = t;
        @(negedge clk);
        upd_valid = 1'b0;
        m_update(pc, t);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic        a_pred;
        logic        last_y;
        logic [PC_W-1:0] pa;

        do_reset();

        // R1: every index predicts not taken after reset.
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            lkp_pc = PC_W'(i << LSB);
            #1;
            chk("R1", pred_taken, 1'b0);
        end

        // R3: one taken outcome moves weakly-not-taken to weakly-taken.
        pa = 32'h0000_0040;
        upd(pa, 1'b1);
        @(negedge clk); lkp_pc = pa; #1;
        chk("R3", pred_taken, 1'b1);
        // R3: drive to saturation at both ends and back.
        for (int i = 0; i < 5; i++) begin upd(pa, 1'b1); look(pa, "R3"); end
        for (int i = 0; i < 6; i++) begin upd(pa, 1'b0); look(pa, "R3"); end
        for (int i = 0; i < 3; i++) begin upd(pa, 1'b1); look(pa, "R3"); end

        // R2: aliases above the index and bits below PC_LSB share the entry.
        @(negedge clk); lkp_pc = pa; #1; a_pred = pred_taken;
        @(negedge clk); lkp_pc = pa | (32'h1 << (LSB + 8)); #1;
        chk("R2", pred_taken, a_pred);
        @(negedge clk); lkp_pc = pa | 32'h3 | 32'h8000_0000; #1;
        chk("R2", pred_taken, a_pred);
        upd(pa | (32'h1 << (LSB + 10)), 1'b0);
        look(pa, "R2");

        // R7: a same-cycle update is seen only after its edge.
        do_reset();
        pa = 32'h0000_0080;
        @(negedge clk);
        lkp_pc = pa; upd_valid = 1'b1; upd_pc = pa; upd_taken = 1'b1;
        #1;
        chk("R7", pred_taken, 1'b0);
        @(posedge clk); #1;
        upd_valid = 1'b0;
        m_update(pa, 1'b1);
        chk("R7", pred_taken, 1'b1);
        look(pa, "R7");

        // R8: update inputs toggle with upd_valid low; nothing changes.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            upd_pc = PC_W'(i << LSB);
            upd_taken = i[0];
        end
        for (int i = 0; i < 8; i++) look(PC_W'(i << LSB), "R8");
        look(pa, "R8");

        // R6: alternating branch; chooser must move to the correlating side.
        do_reset();
        pa = 32'h0000_0100;
        for (int i = 0; i < 24; i++) begin
            look(pa, "R6");
            if (i >= 12) begin
                @(negedge clk); lkp_pc = pa; #1;
                chk("R6", pred_taken, (i % 2) == 0);
            end
            upd(pa, (i % 2) == 0);
        end

        // R5: loop pattern taken x3 then not taken.
        do_reset();
        pa = 32'h0000_0200;
        for (int i = 0; i < 40; i++) begin
            look(pa, "R5");
            upd(pa, (i % 4) != 3);
        end

        // R4: branch Y copies branch X's latest outcome through the history.
        do_reset();
        lfsr = 16'hACE1;
        last_y = 1'b0;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            look(32'h0000_0300, "R4");
            upd(32'h0000_0300, lfsr[0]);
            look(32'h0000_0340, "R4");
            upd(32'h0000_0340, lfsr[0]);
            last_y = lfsr[0];
        end

        // R5: pseudo-random sweep over eight addresses.
        do_reset();
        lfsr = 16'h1D2B;
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pa = PC_W'({lfsr[2:0], 2'b00} << 3) | 32'h0000_0400;
            look(pa, "R5");
            upd(pa, lfsr[7] | (lfsr[5] & lfsr[3]));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule